// File: doc/BRIEF.md
# Parallel Bit Gather Unit

This block takes a 32-bit data word and a 32-bit mask word and gathers the data bits that sit under the mask's set bits. It packs them into the low end of the result. The gathered bits keep their relative order: the lowest selected data bit becomes result bit 0. Every result bit at or above the mask's population count is zero. It is meant as a fixed-latency execution slice inside a larger datapath, and it accepts a new operation on every clock.

The mask is cut into 4-bit groups, and no logic walks the mask bit by bit. Each group packs its own selected bits and counts its own set mask bits. A prefix sum of those counts then gives each group its offset in the result, and a final merge ORs the groups together, each shifted to its offset. The work is spread over three register stages: group packing and counting, prefix offsets, and the shifted merge. A valid flag travels alongside the data through the same stages.

Top module: `bit_gather`

## Requirements
- R1: While reset (rstN low) is applied and after it is released, outVld stays low until a valid operation has passed through the pipeline.
- R2: The selected data bits appear in result bits 0 upward, in their original relative order. For example, mask 0x158 (bits 3, 4, 6, 8) applied to data 0x148 gives 0xD.
- R3: Every result bit at position popcount(inMask) or above is zero.
- R4: A mask of all zeros gives a result of zero, whatever the data.
- R5: A mask of all ones returns the data word unchanged.
- R6: An operation whose inVld is sampled high at rising edge k shows outVld high, with its result on outData, immediately after rising edge k+2, and at no other time.
- R7: Operations presented on consecutive cycles each produce their own correct result on consecutive cycles, in the order they were issued.
- R8: A cycle with inVld low produces a cycle with outVld low three cycles later, and it does not disturb the results of the operations around it.
- R9: A mask with a single set bit at position p gives a result equal to data bit p in bit 0, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inVld | input | 1 | Operation strobe; data and mask are taken when high |
| inData | input | 32 | Word from which bits are gathered |
| inMask | input | 32 | Selection mask; set bits choose data bits |
| outVld | output | 1 | High for the one cycle in which outData holds a result |
| outData | output | 32 | Packed result, zero above the selected bit count |

## Verification
The two things that can happen in the same cycle are accepting a new operation and releasing the result of one issued two edges earlier. At that moment all three stages hold different operations, each with its own offsets. The bench provokes this by streaming long unbroken runs of valid operations, including a full sweep of 16-bit mask patterns and every 12-bit mask. It also mixes in random bubbles. Each cycle, outVld is compared against the due time of the oldest pending operation in an in-order scoreboard, and the data is compared against a gather computed bit by bit in the bench.

// File: rtl/bg_pkg.sv
package bg_pkg;

  // Load strobes from the control to the three datapath stages.
  typedef struct packed {
    logic ld1;  // group pack and count
    logic ld2;  // prefix offsets
    logic ld3;  // shifted merge into result
  } bgStageEn_t;

endpackage

// File: rtl/bg_group.sv
module bg_group #(
  parameter int GRP_W = 4
) (
  input  logic [GRP_W-1:0]               grpData,
  input  logic [GRP_W-1:0]               grpMask,
  output logic [GRP_W-1:0]               grpOut,
  output logic [$clog2(GRP_W+1)-1:0]     grpCount
);

  localparam int GCNT_W = $clog2(GRP_W + 1);
  localparam int IDX_W  = (GRP_W > 1) ? $clog2(GRP_W) : 1;

  logic [GCNT_W-1:0] slot;

  // Packs the selected bits of one small group. The write position is
  // always below GRP_W while a bit is being written.
  always_comb begin
    grpOut = '0;
    slot   = '0;
    for (int i = 0; i < GRP_W; i++) begin
      if (grpMask[i]) begin
        grpOut[slot[IDX_W-1:0]] = grpData[i];
        slot = slot + 1'b1;
      end
    end
    grpCount = slot;
  end

endmodule

// File: rtl/bg_ctrl.sv
module bg_ctrl
  import bg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inVld,
  output bgStageEn_t stageEn,
  output logic       outVld
);

  logic [2:0] vldPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vldPipe <= '0;
    else       vldPipe <= {vldPipe[1:0], inVld};
  end

  always_comb begin
    stageEn.ld1 = inVld;
    stageEn.ld2 = vldPipe[0];
    stageEn.ld3 = vldPipe[1];
  end

  assign outVld = vldPipe[2];

endmodule

// File: rtl/bg_datapath.sv
module bg_datapath
  import bg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int GRP_W  = 4
) (
  input  logic              clk,
  input  bgStageEn_t        stageEn,
  input  logic [DATA_W-1:0] inData,
  input  logic [DATA_W-1:0] inMask,
  output logic [DATA_W-1:0] outData
);

  localparam int NUM_GRP = DATA_W / GRP_W;
  localparam int GCNT_W  = $clog2(GRP_W + 1);
  localparam int CNT_W   = $clog2(DATA_W + 1);

  logic [NUM_GRP-1:0][GRP_W-1:0]  grpRes, grpResS1, grpResS2;
  logic [NUM_GRP-1:0][GCNT_W-1:0] grpCnt, grpCntS1;
  logic [NUM_GRP-1:0][CNT_W-1:0]  grpOff, grpOffS2;
  logic [DATA_W-1:0]              merged;
  logic [CNT_W-1:0]               runSum;

  // Stage 1: independent per-group packing and counting.
  for (genvar g = 0; g < NUM_GRP; g++) begin : gen_grp
    bg_group #(.GRP_W(GRP_W)) u_grp (
      .grpData (inData[g*GRP_W +: GRP_W]),
      .grpMask (inMask[g*GRP_W +: GRP_W]),
      .grpOut  (grpRes[g]),
      .grpCount(grpCnt[g])
    );
  end

  always_ff @(posedge clk) begin
    if (stageEn.ld1) begin
      grpResS1 <= grpRes;
      grpCntS1 <= grpCnt;
    end
  end

  // Stage 2: exclusive prefix sum of the group counts.
  always_comb begin
    runSum = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      grpOff[g] = runSum;
      runSum    = runSum + CNT_W'(grpCntS1[g]);
    end
  end

  always_ff @(posedge clk) begin
    if (stageEn.ld2) begin
      grpResS2 <= grpResS1;
      grpOffS2 <= grpOff;
    end
  end

  // Stage 3: each group shifted to its offset and ORed together.
  always_comb begin
    merged = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      merged = merged | (DATA_W'(grpResS2[g]) << grpOffS2[g]);
    end
  end

  always_ff @(posedge clk) begin
    if (stageEn.ld3) outData <= merged;
  end

endmodule

// File: rtl/bit_gather.sv
module bit_gather
  import bg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int GRP_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inVld,
  input  logic [DATA_W-1:0] inData,
  input  logic [DATA_W-1:0] inMask,
  output logic              outVld,
  output logic [DATA_W-1:0] outData
);

  bgStageEn_t stageEn;

  bg_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inVld  (inVld),
    .stageEn(stageEn),
    .outVld (outVld)
  );

  bg_datapath #(.DATA_W(DATA_W), .GRP_W(GRP_W)) u_dp (
    .clk    (clk),
    .stageEn(stageEn),
    .inData (inData),
    .inMask (inMask),
    .outData(outData)
  );

endmodule

// File: rtl/bit_gather_chk.sv
module bit_gather_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inVld,
  input logic [DATA_W-1:0] inData,
  input logic [DATA_W-1:0] inMask,
  input logic              outVld,
  input logic [DATA_W-1:0] outData
);

  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 1'b1;
  end

  // R1: no result during reset
  always @(negedge clk) begin
    if (!rstN) assert_idle_in_reset_R1: assert (!outVld);
  end

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (outVld == $past(inVld, 3)));

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && outVld) |->
      ((outData >> $countones($past(inMask, 3))) == '0));

  assert_zero_mask_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && outVld && $past(inMask, 3) == '0) |-> (outData == '0));

  assert_full_mask_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && outVld && $past(inMask, 3) == '1) |->
      (outData == $past(inData, 3)));

endmodule

bind bit_gather bit_gather_chk #(.DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .inVld  (inVld),
  .inData (inData),
  .inMask (inMask),
  .outVld (outVld),
  .outData(outData)
);

// File: tb/bit_gather_tb.sv
module bit_gather_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inVld = 1'b0;
  logic [31:0] inData = '0;
  logic [31:0] inMask = '0;
  logic        outVld;
  logic [31:0] outData;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;

  int          dueQ[$];
  logic [31:0] expQ[$];
  logic [31:0] mskQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;  // 50 MHz

  bit_gather u_dut (
    .clk(clk), .rstN(rstN), .inVld(inVld), .inData(inData),
    .inMask(inMask), .outVld(outVld), .outData(outData)
  );

  function automatic logic [31:0] gatherRef(input logic [31:0] d, input logic [31:0] m);
    logic [31:0] r = '0;
    int j = 0;
    for (int k = 0; k < 32; k++) begin
      if (m[k]) begin
        r[j] = d[k];
        j++;
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] nextRand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  // One cycle: check outputs at the falling edge, then drive the next input.
  task automatic step(input logic v, input logic [31:0] d, input logic [31:0] m,
                      input logic [31:0] exp, input string tag);
    logic expV;
    int pop;
    @(negedge clk);
    expV = (dueQ.size() > 0) && (dueQ[0] == cyc);
    checks++;
    if (outVld !== expV) begin
      failures++;
      $display("FAIL R6 R8 outVld at cycle %0d: actual %b expected %b", cyc, outVld, expV);
    end
    if (expV) begin
      checks++;
      if (outData !== expQ[0]) begin
        failures++;
        $display("FAIL %s data: actual %h expected %h", tagQ[0], outData, expQ[0]);
      end
      pop = $countones(mskQ[0]);
      if (pop < 32) begin
        checks++;
        if ((outData >> pop) !== 32'h0) begin
          failures++;
          $display("FAIL R3 upper bits: actual %h expected 0 above bit %0d", outData, pop);
        end
      end
      void'(dueQ.pop_front()); void'(expQ.pop_front());
      void'(mskQ.pop_front()); void'(tagQ.pop_front());
    end
    inVld  = v;
    inData = d;
    inMask = m;
    if (v) begin
      dueQ.push_back(cyc + 3);
      expQ.push_back(exp);
      mskQ.push_back(m);
      tagQ.push_back(tag);
    end
    cyc++;
  endtask

  task automatic op(input logic [31:0] d, input logic [31:0] m, input string tag);
    step(1'b1, d, m, gatherRef(d, m), tag);
  endtask

  task automatic idle();
    step(1'b0, nextRand(), nextRand(), 32'h0, "none");
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    // R1: reset holds the output idle
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      checks++;
      if (outVld !== 1'b0) begin
        failures++;
        $display("FAIL R1 outVld in reset: actual %b expected 0", outVld);
      end
    end
    rstN = 1'b1;
    for (int i = 0; i < 4; i++) idle();

    // R2: worked example, explicit literal
    step(1'b1, 32'h0000_0148, 32'h0000_0158, 32'h0000_000D, "R2");
    // R4: zero mask
    for (int i = 0; i < 8; i++) step(1'b1, nextRand(), 32'h0, 32'h0, "R4");
    // R5: full mask
    for (int i = 0; i < 8; i++) begin
      logic [31:0] d = nextRand();
      step(1'b1, d, 32'hFFFF_FFFF, d, "R5");
    end
    // R9: single-bit masks at every position
    for (int p = 0; p < 32; p++) begin
      logic [31:0] d = nextRand();
      step(1'b1, d, 32'h1 << p, {31'h0, d[p]}, "R9");
    end
    for (int i = 0; i < 4; i++) idle();

    // R2: every 12-bit mask, placed at a sliding nibble offset
    for (int m = 0; m < 4096; m++) begin
      logic [31:0] msk = 32'(m) << (4 * (m % 6));
      op(nextRand(), msk, "R2");
    end
    // R7: unbroken stream over all 16-bit patterns spread across the word
    for (int m = 0; m < 65536; m++) begin
      logic [15:0] h = 16'(m);
      op(nextRand(), {h, ~h ^ 16'(m >> 3)}, "R7");
    end
    // R8: random masks with random bubbles
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r = nextRand();
      if (r[5:4] == 2'b00) idle();
      else op(nextRand(), nextRand() & nextRand() | r, "R8");
    end
    for (int i = 0; i < 6; i++) idle();

    checks++;
    if (dueQ.size() != 0) begin
      failures++;
      $display("FAIL R7 pending results: actual %0d expected 0", dueQ.size());
    end
    finishRun();
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

endmodule